// File: doc/BRIEF.md
# Memory-Mapped I/O Register Block

This block lives next to a processor's data memory and claims every load or store whose address has its top bit set. The processor's store port can update two display registers. Its load port can read those registers, or sample a 32-bit external input bus. Every other address in the upper half of the space accepts accesses and does nothing with them. The block also reports combinationally whether the current address is an I/O access, so the data-memory path can gate its own enables.

Reads are synchronous, with the same timing as the data memory. The block captures address and enable on the rising edge. Its read-data output then selects between the captured I/O value and the memory's read data, steered by the I/O decision that was registered along with the read. An external select line picks which of the two display registers drives the 32-bit output bus. Address decode is an exact 32-bit match, so a display register answers only at its own word address.

Top module: `mmio_regblock`

## Requirements
- R1: `io_space` is 1 in the same cycle whenever `cpu_addr` is 0x80000000 or above, and 0 otherwise.
- R2: A write with `cpu_wr_en`=1 to address 0xFFFFFFF0 loads `cpu_wdata` into the first display register at the rising edge. With `out_sel`=0, `io_out` shows the new value right after that edge.
- R3: A write with `cpu_wr_en`=1 to address 0xFFFFFFF4 loads the second display register at the rising edge. With `out_sel`=1, `io_out` shows the new value right after that edge.
- R4: A write to any address other than exactly 0xFFFFFFF0 or 0xFFFFFFF4 leaves both display registers unchanged. This covers the input port at 0xFFFFFFF8, 0xFFFFFFFC, the range 0x80000000–0xFFFFFFEC and all memory addresses.
- R5: A read with `cpu_rd_en`=1 at 0xFFFFFFF0 or 0xFFFFFFF4 presents that register's value on `rdata` after the edge. When a write to the same register happens in the same cycle, the read returns the value held before the write.
- R6: A read at 0xFFFFFFF8 returns the value `io_in` had at the sampling edge. Later changes of `io_in` do not alter it.
- R7: A read from any other I/O address returns zero on `rdata`.
- R8: After a read edge with an address below 0x80000000, `rdata` follows `mem_rdata`.
- R9: Synchronous active-high reset clears both display registers, so `io_out` is 0 for either select. After reset, `rdata` follows `mem_rdata`.
- R10: `io_out` carries the first display register when `out_sel`=0 and the second when `out_sel`=1. It changes in the same cycle as `out_sel`.
- R11: An I/O read result stays on `rdata` through cycles with `cpu_rd_en`=0, whatever `mem_rdata` does, until the next read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor store data |
| cpu_rd_en | input | 1 | Load request, sampled at the edge |
| cpu_wr_en | input | 1 | Store request, sampled at the edge |
| mem_rdata | input | 32 | Read data from the synchronous data memory |
| io_in | input | 32 | External input bus |
| out_sel | input | 1 | Chooses which display register drives `io_out` |
| io_out | output | 32 | External output bus |
| io_space | output | 1 | High when the current address is an I/O access |
| rdata | output | 32 | Read data returned to the processor |

## Verification
Several properties are checked on every clock: the display registers load on a matching store and hold otherwise, the I/O decode flag, the output-select mapping, zero read data from reserved addresses, input-port sampling, and memory pass-through. Some behaviours only the bench's scenarios show. These are read-before-write ordering within one cycle, a result held through idle cycles while `mem_rdata` moves, and reset clearing values that were written earlier. The bench sweeps every word address in the top 64 bytes, plus boundary addresses on either side of the I/O split and one unaligned address.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned NUM_DISP = 2;

    localparam logic [ADDR_W-1:0] DISP_BASE_ADDR = 32'hFFFF_FFF0;
    localparam logic [ADDR_W-1:0] INPORT_ADDR    = 32'hFFFF_FFF8;

    typedef enum logic [2:0] {
        RGN_MEM    = 3'd0,
        RGN_DISP0  = 3'd1,
        RGN_DISP1  = 3'd2,
        RGN_INPORT = 3'd3,
        RGN_RSVD   = 3'd4
    } region_e;

    typedef struct packed {
        logic    is_io;
        region_e rgn;
    } decode_t;

    function automatic decode_t classify(input logic [ADDR_W-1:0] a);
        decode_t d;
        d.is_io = a[ADDR_W-1];
        if (!a[ADDR_W-1])
            d.rgn = RGN_MEM;
        else if (a == DISP_BASE_ADDR)
            d.rgn = RGN_DISP0;
        else if (a == DISP_BASE_ADDR + 32'd4)
            d.rgn = RGN_DISP1;
        else if (a == INPORT_ADDR)
            d.rgn = RGN_INPORT;
        else
            d.rgn = RGN_RSVD;
        return d;
    endfunction

endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
    import mmio_pkg::*;
#(
    parameter int unsigned NDISP = NUM_DISP
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output decode_t           dec,
    output logic [NDISP-1:0]  disp_we
);
    always_comb dec = classify(addr);

    for (genvar i = 0; i < NDISP; i++) begin : g_we
        always_comb disp_we[i] = wr_en && dec.is_io &&
                                 (addr == DISP_BASE_ADDR + ADDR_W'(4 * i));
    end
endmodule

// File: rtl/mmio_disp_regs.sv
module mmio_disp_regs #(
    parameter int unsigned DW    = 32,
    parameter int unsigned NDISP = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NDISP-1:0]           we,
    input  logic [DW-1:0]              wdata,
    output logic [NDISP-1:0][DW-1:0]   q
);
    for (genvar i = 0; i < NDISP; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= '0;
            else if (we[i])
                q[i] <= wdata;
        end
    end
endmodule

// File: rtl/mmio_rdpath.sv
module mmio_rdpath
    import mmio_pkg::*;
#(
    parameter int unsigned DW    = 32,
    parameter int unsigned NDISP = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rd_en,
    input  decode_t                   dec,
    input  logic [NDISP-1:0][DW-1:0]  disp_q,
    input  logic [DW-1:0]             io_in,
    input  logic [DW-1:0]             mem_rdata,
    output logic [DW-1:0]             rdata
);
    logic [DW-1:0] io_val;
    logic [DW-1:0] io_data_q;
    logic          io_hit_q;

    always_comb begin
        unique case (dec.rgn)
            RGN_DISP0:  io_val = disp_q[0];
            RGN_DISP1:  io_val = disp_q[1];
            RGN_INPORT: io_val = io_in;
            default:    io_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            io_hit_q  <= 1'b0;
            io_data_q <= '0;
        end else if (rd_en) begin
            io_hit_q  <= dec.is_io;
            io_data_q <= io_val;
        end
    end

    always_comb rdata = io_hit_q ? io_data_q : mem_rdata;
endmodule

// File: rtl/mmio_regblock.sv
module mmio_regblock
    import mmio_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    input  logic                cpu_rd_en,
    input  logic                cpu_wr_en,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic [DATA_W-1:0]   io_in,
    input  logic                out_sel,
    output logic [DATA_W-1:0]   io_out,
    output logic                io_space,
    output logic [DATA_W-1:0]   rdata
);
    localparam int unsigned NDISP = NUM_DISP;

    decode_t                        dec;
    logic [NDISP-1:0]               disp_we;
    logic [NDISP-1:0][DATA_W-1:0]   disp_q;

    mmio_decode #(.NDISP(NDISP)) u_dec (
        .addr    (cpu_addr),
        .wr_en   (cpu_wr_en),
        .dec     (dec),
        .disp_we (disp_we)
    );

    mmio_disp_regs #(.DW(DATA_W), .NDISP(NDISP)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (disp_we),
        .wdata (cpu_wdata),
        .q     (disp_q)
    );

    mmio_rdpath #(.DW(DATA_W), .NDISP(NDISP)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (cpu_rd_en),
        .dec       (dec),
        .disp_q    (disp_q),
        .io_in     (io_in),
        .mem_rdata (mem_rdata),
        .rdata     (rdata)
    );

    always_comb io_space = dec.is_io;
    always_comb io_out   = disp_q[out_sel];
endmodule

// File: rtl/mmio_regblock_chk.sv
module mmio_regblock_chk #(
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [31:0]   cpu_addr,
    input logic [DW-1:0] cpu_wdata,
    input logic          cpu_rd_en,
    input logic          cpu_wr_en,
    input logic [DW-1:0] mem_rdata,
    input logic [DW-1:0] io_in,
    input logic          out_sel,
    input logic [DW-1:0] io_out,
    input logic          io_space,
    input logic [DW-1:0] rdata,
    input logic [DW-1:0] dp0,
    input logic [DW-1:0] dp1
);
    logic hit0, hit1, hitin, rsvd;
    always_comb begin
        hit0  = cpu_addr == 32'hFFFF_FFF0;
        hit1  = cpu_addr == 32'hFFFF_FFF4;
        hitin = cpu_addr == 32'hFFFF_FFF8;
        rsvd  = cpu_addr[31] && !hit0 && !hit1 && !hitin;
    end

    // R1
    io_decode_chk: assert property (@(posedge clk) disable iff (rst)
        io_space == (cpu_addr >= 32'h8000_0000));
    // R2
    dp0_load_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_wr_en && hit0 |=> dp0 == $past(cpu_wdata));
    // R3
    dp1_load_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_wr_en && hit1 |=> dp1 == $past(cpu_wdata));
    // R4
    dp0_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wr_en && hit0) |=> $stable(dp0));
    // R4
    dp1_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wr_en && hit1) |=> $stable(dp1));
    // R6
    inport_read_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_rd_en && hitin |=> rdata == $past(io_in));
    // R7
    rsvd_read_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_rd_en && rsvd |=> rdata == '0);
    // R8
    mem_read_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_rd_en && !cpu_addr[31] |=> rdata == mem_rdata);
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (dp0 == '0 && dp1 == '0));
    // R10
    out_sel_chk: assert property (@(posedge clk) disable iff (rst)
        io_out == (out_sel ? dp1 : dp0));
endmodule

bind mmio_regblock mmio_regblock_chk #(.DW(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rd_en (cpu_rd_en),
    .cpu_wr_en (cpu_wr_en),
    .mem_rdata (mem_rdata),
    .io_in     (io_in),
    .out_sel   (out_sel),
    .io_out    (io_out),
    .io_space  (io_space),
    .rdata     (rdata),
    .dp0       (disp_q[0]),
    .dp1       (disp_q[1])
);

// File: tb/test_mmio_regblock.sv
`timescale 1ns/1ps
module test_mmio_regblock;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_rd_en = 1'b0;
    logic        cpu_wr_en = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] io_in = '0;
    logic        out_sel = 1'b0;
    logic [31:0] io_out;
    logic        io_space;
    logic [31:0] rdata;

    int errors = 0;
    int checks = 0;
    logic [31:0] m_dp0 = '0;
    logic [31:0] m_dp1 = '0;

    always #2.5 clk = ~clk;

    mmio_regblock i_mmio_regblock (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd_en(cpu_rd_en), .cpu_wr_en(cpu_wr_en), .mem_rdata(mem_rdata),
        .io_in(io_in), .out_sel(out_sel), .io_out(io_out),
        .io_space(io_space), .rdata(rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] addr_of(input int k);
        if (k < 16) return 32'hFFFF_FFC0 + 32'(4 * k);
        case (k)
            16: return 32'h8000_0000;
            17: return 32'h7FFF_FFFC;
            18: return 32'h0000_0040;
            default: return 32'hFFFF_FFF1;
        endcase
    endfunction

    // expected load result for an I/O address (requirements R5, R6, R7)
    function automatic logic [31:0] exp_io(input logic [31:0] a, input logic [31:0] inp);
        if (a == 32'hFFFF_FFF0) return m_dp0;
        if (a == 32'hFFFF_FFF4) return m_dp1;
        if (a == 32'hFFFF_FFF8) return inp;
        return 32'h0;
    endfunction

    task automatic clk_edge();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_outs(input string req);
        out_sel = 1'b0; #0.1;
        chk({req, " io_out sel0"}, io_out, m_dp0);
        out_sel = 1'b1; #0.1;
        chk({req, " io_out sel1"}, io_out, m_dp1);
        out_sel = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] a, wd, inv, held;
        @(negedge clk);
        clk_edge();
        rst = 1'b0;
        mem_rdata = 32'h1357_9BDF; #0.1;
        check_outs("R9 reset");
        chk("R9 rdata after reset", rdata, 32'h1357_9BDF);

        for (int k = 0; k < 20; k++) begin
            a  = addr_of(k);
            wd = 32'hA5C3_0000 ^ (a << 4) ^ 32'(k);
            // store
            cpu_addr = a; cpu_wdata = wd; cpu_wr_en = 1'b1; #0.1;
            checks++;
            if (io_space !== a[31]) begin
                errors++;
                $display("FAIL R1: actual=%0b expected=%0b addr=0x%08h", io_space, a[31], a);
            end
            clk_edge();
            cpu_wr_en = 1'b0;
            if (a == 32'hFFFF_FFF0) m_dp0 = wd;
            if (a == 32'hFFFF_FFF4) m_dp1 = wd;
            check_outs("R2/R3/R4 store");
            // load
            inv = 32'hC0DE_0000 | 32'(k);
            io_in = ~a; mem_rdata = 32'hDEAD_BEEF; cpu_rd_en = 1'b1;
            clk_edge();
            cpu_rd_en = 1'b0;
            io_in = 32'h5555_AAAA; mem_rdata = inv; #0.1;
            if (a[31]) begin
                held = exp_io(a, ~a);
                chk("R5/R6/R7 io read", rdata, held);
            end else begin
                held = inv;
                chk("R8 mem read", rdata, inv);
            end
            // idle cycle with changing memory data
            mem_rdata = 32'h0BAD_0000 | 32'(k);
            clk_edge(); #0.1;
            chk("R11 hold / R8 follow", rdata, a[31] ? held : (32'h0BAD_0000 | 32'(k)));
        end

        // R5 read-before-write on the same register
        cpu_addr = 32'hFFFF_FFF0; cpu_wdata = 32'h0F0F_1234;
        cpu_rd_en = 1'b1; cpu_wr_en = 1'b1;
        clk_edge();
        cpu_rd_en = 1'b0; cpu_wr_en = 1'b0; #0.1;
        chk("R5 read-before-write rdata", rdata, m_dp0);
        m_dp0 = 32'h0F0F_1234;
        check_outs("R5 read-before-write store");

        // R10 same-cycle select change after both registers are loaded
        cpu_addr = 32'hFFFF_FFF4; cpu_wdata = 32'h7777_0001; cpu_wr_en = 1'b1;
        clk_edge();
        cpu_wr_en = 1'b0; m_dp1 = 32'h7777_0001;
        out_sel = 1'b1; #0.1;
        chk("R10 sel1", io_out, m_dp1);
        out_sel = 1'b0; #0.1;
        chk("R10 sel0", io_out, m_dp0);

        // R9 mid-run reset clears written registers
        rst = 1'b1;
        clk_edge();
        rst = 1'b0;
        m_dp0 = '0; m_dp1 = '0;
        mem_rdata = 32'h2468_ACE0; #0.1;
        check_outs("R9 mid-run reset");
        chk("R9 rdata after mid-run reset", rdata, 32'h2468_ACE0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule